// File: doc/BRIEF.md
# Programmable-Bin Energy Histogrammer

The block takes a stream of particle events, each an energy value with a direction tag, and sorts them into energy bins. Each direction tag has its own histogram. Bin edges come from a set of software-writable thresholds, so a narrow energy range can get fine bins while a wide range shares one coarse bin. Counting runs over a collection period whose length in clock cycles is also programmable.

When a period ends, the counts of that period are frozen in one of two banks. Counting carries on at once in the other bank. The frozen bank is then streamed out over a valid/ready interface toward a memory controller. For each direction, a header word comes first, followed by one word per bin. Every entry is cleared as its word is accepted. The header names the period by sequence number, the direction, and a layout version. The layout version changes whenever the thresholds or the period length were reprogrammed, so a reader can tell which bin edges and which collection time produced the counts.

Top module: `energy_binner`

## Requirements
- R1: After reset, `outValid` is low, every count is zero, the period sequence number is 0 and the layout version is 0. The first dump follows only when the first period has run out.
- R2: With thresholds T0 < T1 < ... < T(NBIN-2), an energy goes to the lowest bin i with E < Ti. An energy at or above the last threshold goes to bin NBIN-1. The reset thresholds are (i+1)*2^EW/NBIN, which is 64, 128 and 192 for the defaults.
- R3: Counts are kept separately for each direction tag. An event changes only the count of its own tag.
- R4: A count stops at its maximum value (15 for CW=4) and does not wrap.
- R5: A collection period lasts `periodData` cycles, 64 after reset. A new length written during a period applies from the next period on.
- R6: A threshold write applies only from the start of the next collection period. Events in the current period are still binned with the old edges.
- R7: A dump sends, for direction 0 and then each higher direction, one header word followed by NBIN count words in ascending bin order. A header word has bit 9 set. A count word has bit 9 clear, bits 8:6 zero, the bin index in bits 5:4 and the count in bits 3:0.
- R8: A header word carries the period sequence number in bits 8:5, the direction in bit 4 and the layout version in bits 3:0. The layout version goes up by one at the end of any period in which a threshold or the period length was written.
- R9: Each count is zero again after its dump word has been accepted. The next dump of that bank therefore shows only new events.
- R10: An event that arrives in any cycle is counted in exactly one period. Events around a period boundary are not lost.
- R11: While `outReady` is low, `outValid` stays high and `outData` holds its value. The end of a period waits until the previous dump has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event present this cycle |
| evEnergy | input | EW | Combined event energy |
| evDir | input | DW | Direction tag of the event |
| thrWe | input | 1 | Write strobe for a bin threshold |
| thrIdx | input | BW | Threshold index, 0 to NBIN-2 |
| thrData | input | EW | New threshold value |
| periodWe | input | 1 | Write strobe for the period length |
| periodData | input | PW | New period length in cycles |
| outValid | output | 1 | Dump word available |
| outReady | input | 1 | Downstream accepts the word |
| outData | output | OW | Header or count word |

## Verification
The in-line assertions check four things on every cycle: a stalled word holds steady, every dump opens with a header, a count at its ceiling stays there, and an accepted entry reads zero on the next cycle. They also check that the active bin edges move only at a period boundary. The bench scenarios are needed for the rest: the bin chosen for edge energies, the separation between directions, the sequence and layout-version fields, and the real period length measured between dumps. A burst of events straddling a boundary shows that the two dumps together account for every event. That fact depends on the bench knowing how many events it sent.

// File: rtl/ebin_pkg.sv
package ebin_pkg;
  typedef struct packed {
    logic commit;     // period boundary: swap banks, load new edges
    logic actBank;    // bank currently counting
    logic wordTaken;  // a count word of the dump bank was accepted
  } ebin_strobe_t;
endpackage

// File: rtl/ebin_datapath.sv
module ebin_datapath
  import ebin_pkg::*;
#(
  parameter int EW   = 8,
  parameter int NDIR = 2,
  parameter int NBIN = 4,
  parameter int CW   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ebin_strobe_t               strobe,
  input  logic                       evValid,
  input  logic [EW-1:0]              evEnergy,
  input  logic [$clog2(NDIR)-1:0]    evDir,
  input  logic                       thrWe,
  input  logic [$clog2(NBIN)-1:0]    thrIdx,
  input  logic [EW-1:0]              thrData,
  input  logic [$clog2(NDIR)-1:0]    dumpDir,
  input  logic [$clog2(NBIN)-1:0]    dumpBin,
  output logic [CW-1:0]              dumpCount
);
  localparam int DW   = $clog2(NDIR);
  localparam int BW   = $clog2(NBIN);
  localparam int STEP = (2 ** EW) / NBIN;

  logic [NBIN-2:0][EW-1:0] shadowThr, actThr;
  logic [CW-1:0] bank [2][NDIR][NBIN];
  logic [BW-1:0] evBin;
  logic          dirOk;
  logic [CW-1:0] hitCnt;

  always_comb begin
    evBin = BW'(NBIN - 1);
    for (int i = NBIN - 2; i >= 0; i--)
      if (evEnergy < actThr[i]) evBin = BW'(i);
  end

  assign dirOk     = {1'b0, evDir} < (DW + 1)'(NDIR);
  assign hitCnt    = bank[strobe.actBank][evDir][evBin];
  assign dumpCount = bank[~strobe.actBank][dumpDir][dumpBin];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NBIN - 1; i++) begin
        shadowThr[i] <= EW'((i + 1) * STEP);
        actThr[i]    <= EW'((i + 1) * STEP);
      end
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < NDIR; d++)
          for (int k = 0; k < NBIN; k++)
            bank[b][d][k] <= '0;
    end else begin
      if (thrWe && ({1'b0, thrIdx} < (BW + 1)'(NBIN - 1)))
        shadowThr[thrIdx] <= thrData;
      if (strobe.commit) actThr <= shadowThr;
      if (evValid && dirOk && (hitCnt != {CW{1'b1}}))
        bank[strobe.actBank][evDir][evBin] <= hitCnt + 1'b1;
      if (strobe.wordTaken)
        bank[~strobe.actBank][dumpDir][dumpBin] <= '0;
    end
  end

  // checker state: remember the entry touched last cycle
  logic          satPend, clrPend;
  logic          satBank, clrBank;
  logic [DW-1:0] satDir, clrDir;
  logic [BW-1:0] satBin, clrBin;
  logic [CW-1:0] satNow, clrNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      satPend <= 1'b0; clrPend <= 1'b0;
      satBank <= 1'b0; clrBank <= 1'b0;
      satDir  <= '0;   clrDir  <= '0;
      satBin  <= '0;   clrBin  <= '0;
    end else begin
      satPend <= evValid && dirOk && (hitCnt == {CW{1'b1}}) && !strobe.commit;
      satBank <= strobe.actBank; satDir <= evDir; satBin <= evBin;
      clrPend <= strobe.wordTaken && !strobe.commit;
      clrBank <= ~strobe.actBank; clrDir <= dumpDir; clrBin <= dumpBin;
    end
  end

  assign satNow = bank[satBank][satDir][satBin];
  assign clrNow = bank[clrBank][clrDir][clrBin];

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    satPend |-> (satNow == {CW{1'b1}}));
  assert_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrPend |-> (clrNow == '0));
  assert_edges_deferred_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(actThr));
endmodule

// File: rtl/ebin_ctrl.sv
module ebin_ctrl
  import ebin_pkg::*;
#(
  parameter int NDIR       = 2,
  parameter int NBIN       = 4,
  parameter int CW         = 4,
  parameter int PW         = 16,
  parameter int SW         = 4,
  parameter int LW         = 4,
  parameter int DEF_PERIOD = 64,
  parameter int OW         = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       thrWe,
  input  logic                       periodWe,
  input  logic [PW-1:0]              periodData,
  input  logic [CW-1:0]              dumpCount,
  input  logic                       outReady,
  output logic                       outValid,
  output logic [OW-1:0]              outData,
  output ebin_strobe_t               strobe,
  output logic [$clog2(NDIR)-1:0]    dumpDir,
  output logic [$clog2(NBIN)-1:0]    dumpBin
);
  localparam int DW  = $clog2(NDIR);
  localparam int BW  = $clog2(NBIN);
  localparam int SLW = $clog2(NBIN + 1);

  logic [PW-1:0]  periodCnt, curPeriod, shadowPeriod;
  logic           actBank, dumping, pending;
  logic [DW-1:0]  dDir;
  logic [SLW-1:0] slot;
  logic [SW-1:0]  seq, dumpSeq;
  logic [LW-1:0]  ver, dumpVer;
  logic           termHit, expire, take, lastSlot, lastDir;

  assign termHit  = ({1'b0, periodCnt} + (PW + 1)'(1)) >= {1'b0, curPeriod};
  assign expire   = termHit && !dumping;
  assign take     = dumping && outReady;
  assign lastSlot = slot == SLW'(NBIN);
  assign lastDir  = dDir == DW'(NDIR - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt    <= '0;
      curPeriod    <= PW'(DEF_PERIOD);
      shadowPeriod <= PW'(DEF_PERIOD);
      actBank      <= 1'b0;
      dumping      <= 1'b0;
      pending      <= 1'b0;
      dDir         <= '0;
      slot         <= '0;
      seq          <= '0;
      dumpSeq      <= '0;
      ver          <= '0;
      dumpVer      <= '0;
    end else begin
      if (periodWe) shadowPeriod <= periodData;
      if (expire) begin
        periodCnt <= '0;
        curPeriod <= shadowPeriod;
        actBank   <= ~actBank;
        dumping   <= 1'b1;
        dDir      <= '0;
        slot      <= '0;
        dumpSeq   <= seq;
        seq       <= seq + 1'b1;
        dumpVer   <= ver;
        if (pending) ver <= ver + 1'b1;
        pending   <= thrWe | periodWe;
      end else begin
        if (!termHit) periodCnt <= periodCnt + 1'b1;
        pending <= pending | thrWe | periodWe;
      end
      if (take) begin
        if (lastSlot) begin
          slot <= '0;
          if (lastDir) dumping <= 1'b0;
          else         dDir    <= dDir + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  assign outValid = dumping;
  assign dumpDir  = dDir;
  assign dumpBin  = BW'(slot - 1'b1);

  always_comb begin
    outData = '0;
    if (slot == '0) begin
      outData[OW-1]             = 1'b1;
      outData[SW+DW+LW-1:0]     = {dumpSeq, dDir, dumpVer};
    end else begin
      outData[BW+CW-1:0]        = {dumpBin, dumpCount};
    end
  end

  assign strobe.commit    = expire;
  assign strobe.actBank   = actBank;
  assign strobe.wordTaken = take && (slot != '0);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  assert_header_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outData[OW-1]);
endmodule

// File: rtl/energy_binner.sv
module energy_binner
  import ebin_pkg::*;
#(
  parameter int EW         = 8,
  parameter int NDIR       = 2,
  parameter int NBIN       = 4,
  parameter int CW         = 4,
  parameter int PW         = 16,
  parameter int SW         = 4,
  parameter int LW         = 4,
  parameter int DEF_PERIOD = 64,
  localparam int DW        = $clog2(NDIR),
  localparam int BW        = $clog2(NBIN),
  localparam int HW        = 1 + SW + DW + LW,
  localparam int KW        = 1 + BW + CW,
  localparam int OW        = (HW > KW) ? HW : KW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           evValid,
  input  logic [EW-1:0]  evEnergy,
  input  logic [DW-1:0]  evDir,
  input  logic           thrWe,
  input  logic [BW-1:0]  thrIdx,
  input  logic [EW-1:0]  thrData,
  input  logic           periodWe,
  input  logic [PW-1:0]  periodData,
  output logic           outValid,
  input  logic           outReady,
  output logic [OW-1:0]  outData
);
  ebin_strobe_t  strobe;
  logic [DW-1:0] dumpDir;
  logic [BW-1:0] dumpBin;
  logic [CW-1:0] dumpCount;

  ebin_ctrl #(
    .NDIR(NDIR), .NBIN(NBIN), .CW(CW), .PW(PW), .SW(SW), .LW(LW),
    .DEF_PERIOD(DEF_PERIOD), .OW(OW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .thrWe(thrWe), .periodWe(periodWe),
    .periodData(periodData), .dumpCount(dumpCount), .outReady(outReady),
    .outValid(outValid), .outData(outData), .strobe(strobe),
    .dumpDir(dumpDir), .dumpBin(dumpBin)
  );

  ebin_datapath #(
    .EW(EW), .NDIR(NDIR), .NBIN(NBIN), .CW(CW)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evValid(evValid),
    .evEnergy(evEnergy), .evDir(evDir), .thrWe(thrWe), .thrIdx(thrIdx),
    .thrData(thrData), .dumpDir(dumpDir), .dumpBin(dumpBin),
    .dumpCount(dumpCount)
  );
endmodule

// File: tb/energy_binner_bench.sv
module energy_binner_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic [7:0]  evEnergy = '0;
  logic [0:0]  evDir = '0;
  logic        thrWe = 1'b0;
  logic [1:0]  thrIdx = '0;
  logic [7:0]  thrData = '0;
  logic        periodWe = 1'b0;
  logic [15:0] periodData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [9:0]  outData;

  always #4 clk = ~clk;

  energy_binner u_energy_binner (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evEnergy(evEnergy),
    .evDir(evDir), .thrWe(thrWe), .thrIdx(thrIdx), .thrData(thrData),
    .periodWe(periodWe), .periodData(periodData), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  int nRun = 0, nFail = 0, cyc = 0, wrPtr = 0;
  logic [9:0] wordBuf [0:127];
  int capTime [0:127];

  always @(posedge clk) cyc++;
  always @(negedge clk)
    if (rstN && outValid && outReady && wrPtr < 128) begin
      wordBuf[wrPtr] = outData;
      capTime[wrPtr] = cyc;
      wrPtr++;
    end

  // energy[10:3], dir[2], expected bin[1:0] under reset thresholds 64/128/192
  localparam logic [10:0] VEC [12] = '{
    {8'd0,   1'b0, 2'd0}, {8'd63,  1'b1, 2'd0}, {8'd64,  1'b0, 2'd1},
    {8'd127, 1'b1, 2'd1}, {8'd128, 1'b0, 2'd2}, {8'd191, 1'b1, 2'd2},
    {8'd192, 1'b0, 2'd3}, {8'd255, 1'b1, 2'd3}, {8'd10,  1'b1, 2'd0},
    {8'd100, 1'b1, 2'd1}, {8'd200, 1'b1, 2'd3}, {8'd150, 1'b0, 2'd2}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic waitWords(input int n);
    while (wrPtr < n) @(posedge clk);
    #1;
  endtask

  task automatic sendEv(input logic [7:0] e, input logic d);
    @(posedge clk); #1;
    evValid = 1'b1; evEnergy = e; evDir = d;
    @(posedge clk); #1;
    evValid = 1'b0;
  endtask

  task automatic checkDump(input int k, input int s, input int v,
                           input int e [2][4], input string ctag);
    logic [9:0] w;
    for (int d = 0; d < 2; d++) begin
      w = wordBuf[k*10 + d*5];
      chk(w[9] == 1'b1, "R7 header kind", int'(w[9]), 1);
      chk(w[8:5] == 4'(s), "R8 header seq", int'(w[8:5]), s);
      chk(w[4] == 1'(d), "R8 header dir", int'(w[4]), d);
      chk(w[3:0] == 4'(v), "R8 header layout version", int'(w[3:0]), v);
      for (int b = 0; b < 4; b++) begin
        w = wordBuf[k*10 + d*5 + 1 + b];
        chk(w[9:6] == 4'd0 && w[5:4] == 2'(b), "R7 count word order",
            int'(w[9:4]), b);
        chk(w[3:0] == 4'(e[d][b]), ctag, int'(w[3:0]), e[d][b]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R10 actual words=%0d expected=80", wrPtr);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int zero [2][4];
    int tab [2][4];
    int n6, n7;
    logic [9:0] held;
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 4; b++) begin zero[d][b] = 0; tab[d][b] = 0; end

    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    #2;
    chk(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    repeat (10) @(posedge clk); #1;
    chk(wrPtr == 0, "R1 no dump before first period ends", wrPtr, 0);

    // period 1: table of events
    waitWords(1);
    for (int i = 0; i < 12; i++) begin
      tab[VEC[i][2]][VEC[i][1:0]]++;
      sendEv(VEC[i][10:3], VEC[i][2]);
    end
    waitWords(20);
    checkDump(0, 0, 0, zero, "R1 empty first dump");
    checkDump(1, 1, 0, tab, "R2 R3 bin count");

    // period 2: saturation burst, edge event, deferred threshold write
    @(posedge clk); #1;
    evValid = 1'b1; evEnergy = 8'd5; evDir = 1'b1;
    repeat (20) @(posedge clk); #1;
    evValid = 1'b0;
    sendEv(8'd20, 1'b0);
    @(posedge clk); #1;
    thrWe = 1'b1; thrIdx = 2'd0; thrData = 8'd10;
    @(posedge clk); #1;
    thrWe = 1'b0;

    // period 3: new edge applies, shorter period written
    waitWords(21);
    sendEv(8'd20, 1'b0);
    @(posedge clk); #1;
    periodWe = 1'b1; periodData = 16'd32;
    @(posedge clk); #1;
    periodWe = 1'b0;
    waitWords(30);
    outReady = 1'b0;
    repeat (80) @(posedge clk); #1;
    chk(outValid == 1'b1, "R11 valid held under stall", int'(outValid), 1);
    chk(wrPtr == 30, "R11 nothing taken under stall", wrPtr, 30);
    held = outData;
    repeat (3) @(posedge clk); #1;
    chk(outData == held, "R11 data stable under stall", int'(outData), int'(held));
    chk(outData[9] == 1'b1, "R7 stalled word is header", int'(outData[9]), 1);
    outReady = 1'b1;
    waitWords(40);

    tab = zero; tab[1][0] = 15; tab[0][0] = 1;
    checkDump(2, 2, 0, tab, "R4 R6 saturation and old edges");
    tab = zero; tab[0][1] = 1;
    checkDump(3, 3, 1, tab, "R6 R9 new edge and cleared bank");

    // period 6: burst straddling a boundary
    waitWords(51);
    repeat (25) @(posedge clk); #1;
    evValid = 1'b1; evEnergy = 8'd200; evDir = 1'b0;
    repeat (14) @(posedge clk); #1;
    evValid = 1'b0;
    waitWords(80);

    checkDump(4, 4, 2, zero, "R9 empty dump after clear");
    checkDump(5, 5, 2, zero, "R9 empty dump");
    chk(capTime[60] - capTime[50] == 32, "R5 programmed period length",
        capTime[60] - capTime[50], 32);
    chk(capTime[70] - capTime[60] == 32, "R5 period length repeat",
        capTime[70] - capTime[60], 32);
    n6 = int'(wordBuf[64][3:0]);
    n7 = int'(wordBuf[74][3:0]);
    chk(n6 + n7 == 14, "R10 no event lost at boundary", n6 + n7, 14);
    chk(n6 > 0 && n7 > 0, "R10 burst split over two periods", n6 * 100 + n7, 1);
    chk(wordBuf[60][8:5] == 4'd6 && wordBuf[70][8:5] == 4'd7, "R8 seq after boundary",
        int'(wordBuf[70][8:5]), 7);
    chk(wordBuf[69][3:0] == 4'd0, "R3 other direction untouched",
        int'(wordBuf[69][3:0]), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule